// File: doc/BRIEF.md
# Three-Slot Aged Receive Frame Buffer

This block sits behind a byte-level bus receiver and parks complete received frames in one of three slots until software collects them. Alongside every occupied slot it keeps a two-bit age rank, so software reading the packed status word always knows which slot holds the oldest frame. Releasing a slot moves every younger frame one rank closer to the front. Frames therefore stay in arrival order however software interleaves reads and releases.

The receiver side uses three single-cycle strobes. `rx_start` opens a frame. `rx_valid` delivers one byte on `rx_data`. `rx_end` closes the frame. A small capture state machine handles the frame and has three states:
- `ST_IDLE` waits for a frame.
- `ST_CAPTURE` writes bytes into the slot reserved at the start.
- `ST_DROP` swallows a frame for which no slot was free.

The transitions are:
- `rx_start` moves from any state to `ST_CAPTURE` when a slot is free, and to `ST_DROP` otherwise.
- `rx_end` returns `ST_CAPTURE` and `ST_DROP` to `ST_IDLE`.
- Nothing else moves the state.

Software uses a plain register port with a write strobe and a combinational read path. Each slot drives its own ready interrupt line.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset every slot is empty, the status word (0x33), the control register (0x34) and every length (0x30..0x32) read 0, and `slot_irq` and `overflow` are low.
- R2: The status word at 0x33 holds a 2-bit rank per slot in bits [1:0], [3:2] and [5:4] for slots 0, 1 and 2, and the sticky overflow flag in bit 7. Rank 0 means empty, 1 the oldest frame, 2 the next and 3 the youngest. Occupied slots always hold distinct ranks no larger than the number of occupied slots.
- R3: A completed frame goes into the lowest-indexed empty slot. Its rank equals the number of occupied slots after it is inserted. Its rank, length and `slot_irq` bit become visible in the cycle after the `rx_end` clock edge, and `slot_irq[i]` is high exactly while slot i is occupied.
- R4: Byte k of the frame in slot s reads at address s*16+k, with the header as k=0. The slot's 5-bit length reads at address 0x30+s.
- R5: A frame holds at most 16 bytes. Bytes past the 16th are dropped and the length saturates at 16.
- R6: Writing the control register with clear bit s (bit s, for s = 0..2) at 1, and then with that bit at 0, empties slot s on the second write. Its length then reads 0, and every occupied slot with a higher rank drops by one.
- R7: Control bit 3 selects multi-slot operation. While it is 0, only slot 0 can receive.
- R8: A frame that starts while no permitted slot is empty is discarded, and bit 7 of the status word and the `overflow` pin are set and stay set.
- R9: Writing 0x0F to the control register empties all slots and clears the overflow flag in the next cycle. A frame commit in that same cycle is lost.
- R10: A frame that ends without any byte changes no slot.
- R11: An `rx_start` in the middle of a frame abandons the partial frame and starts a new frame in a freshly chosen slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Byte strobe for rx_data |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Frame end strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| slot_irq | output | 3 | Per-slot ready interrupt |
| overflow | output | 1 | Sticky discarded-frame flag |

## Verification
Every slot update, covering commit, release and clear-all, lands on the clock edge that samples the strobe. Its result is therefore visible one cycle later. Read data follows `reg_addr` with no register in between. The stimulus tasks change inputs on the falling edge and return only after the edge that consumes the strobe has passed. The scoreboard monitor pops each expected item on a later falling edge, sets the address and samples 2 ns afterwards, well clear of any rising edge. The driver waits for the queue to drain before it applies new stimulus, so no check can see a half-updated state.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
    localparam int NSLOT   = 3;
    localparam int RANK_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int MAX_LEN = 16;
    localparam int IDX_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int ADDR_W  = 6;

    localparam logic [ADDR_W-1:0] A_LEN_BASE = 6'h30;
    localparam logic [ADDR_W-1:0] A_STATUS   = 6'h33;
    localparam logic [ADDR_W-1:0] A_CTRL     = 6'h34;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_DROP
    } cap_state_e;
endpackage

// File: rtl/rxfb_frame_fsm.sv
module rxfb_frame_fsm
    import rxfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic              rx_end,
    input  logic [NSLOT-1:0]  free_mask,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              commit,
    output logic [LEN_W-1:0]  commit_len,
    output logic              ovf_set
);
    cap_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] pick;
    logic              free_any;

    always_comb begin
        pick     = '0;
        free_any = |free_mask;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (free_mask[i]) pick = SLOT_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rx_start) begin
            state_d = free_any ? ST_CAPTURE : ST_DROP;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_CAPTURE: if (rx_end) state_d = ST_IDLE;
                ST_DROP:    if (rx_end) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en      = 1'b0;
        commit     = 1'b0;
        ovf_set    = rx_start && !free_any;
        wr_slot    = slot_q;
        wr_idx     = cnt_q[IDX_W-1:0];
        unique case (state_q)
            ST_CAPTURE: begin
                wr_en  = rx_valid && !rx_start && (cnt_q < LEN_W'(MAX_LEN));
                commit = rx_end && !rx_start;
            end
            default: begin
                wr_en  = 1'b0;
                commit = 1'b0;
            end
        endcase
        commit_len = cnt_q + {{(LEN_W-1){1'b0}}, wr_en};
        if (commit_len == '0) commit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (rx_start) begin
            cnt_q <= '0;
            if (free_any) slot_q <= pick;
        end else if (wr_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxfb_slot_store.sv
module rxfb_slot_store
    import rxfb_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [SLOT_W-1:0] rslot,
    input  logic [IDX_W-1:0]  ridx,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] rd_slot [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [BYTE_W-1:0] mem [MAX_LEN];
        always_ff @(posedge clk) begin
            if (we && wslot == SLOT_W'(s)) mem[widx] <= wdata;
        end
        assign rd_slot[s] = mem[ridx];
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rslot == SLOT_W'(s)) rdata = rd_slot[s];
        end
    end
endmodule

// File: rtl/rxfb_age_tracker.sv
module rxfb_age_tracker
    import rxfb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [SLOT_W-1:0]       commit_slot,
    input  logic [LEN_W-1:0]        commit_len,
    input  logic [NSLOT-1:0]        release_mask,
    input  logic                    clear_all,
    input  logic                    ovf_set,
    output logic [NSLOT*RANK_W-1:0] ranks,
    output logic [NSLOT*LEN_W-1:0]  lens,
    output logic                    overflow
);
    logic [RANK_W-1:0] rank_q [NSLOT];
    logic [RANK_W-1:0] rank_d [NSLOT];
    logic [RANK_W-1:0] kept   [NSLOT];
    logic [NSLOT-1:0]  gone;
    logic [RANK_W-1:0] occ;
    logic              ovf_q;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            gone[i] = release_mask[i] && (rank_q[i] != '0);
        end
        occ = '0;
        for (int i = 0; i < NSLOT; i++) begin
            kept[i] = rank_q[i];
            if (gone[i]) begin
                kept[i] = '0;
            end else if (rank_q[i] != '0) begin
                for (int j = 0; j < NSLOT; j++) begin
                    if (gone[j] && rank_q[j] < rank_q[i]) kept[i] = kept[i] - 1'b1;
                end
            end
            if (kept[i] != '0) occ = occ + 1'b1;
        end
        for (int i = 0; i < NSLOT; i++) begin
            if (clear_all)                                   rank_d[i] = '0;
            else if (commit && commit_slot == SLOT_W'(i))    rank_d[i] = occ + 1'b1;
            else                                             rank_d[i] = kept[i];
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [LEN_W-1:0] len_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rank_q[s] <= '0;
                len_q     <= '0;
            end else begin
                rank_q[s] <= rank_d[s];
                if (clear_all || gone[s])                          len_q <= '0;
                else if (commit && commit_slot == SLOT_W'(s))     len_q <= commit_len;
            end
        end
        assign ranks[s*RANK_W +: RANK_W] = rank_q[s];
        assign lens[s*LEN_W +: LEN_W]    = len_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (clear_all) ovf_q <= 1'b0;
        else if (ovf_set)   ovf_q <= 1'b1;
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
    import rxfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [NSLOT-1:0]  slot_irq,
    output logic              overflow
);
    logic [3:0]                ctrl_q;
    logic                      ctrl_wr;
    logic [NSLOT-1:0]          release_mask;
    logic                      clear_all;
    logic [NSLOT-1:0]          empty_mask;
    logic [NSLOT-1:0]          free_mask;
    logic                      wr_en;
    logic [SLOT_W-1:0]         wr_slot;
    logic [IDX_W-1:0]          wr_idx;
    logic                      commit;
    logic [LEN_W-1:0]          commit_len;
    logic                      ovf_set;
    logic [NSLOT*RANK_W-1:0]   ranks;
    logic [NSLOT*LEN_W-1:0]    lens;
    logic [BYTE_W-1:0]         store_rdata;

    assign ctrl_wr      = reg_wr && (reg_addr == A_CTRL);
    assign release_mask = ctrl_wr ? (ctrl_q[NSLOT-1:0] & ~reg_wdata[NSLOT-1:0]) : '0;
    assign clear_all    = ctrl_wr && (reg_wdata[3:0] == 4'hF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata[3:0];
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_irq
        assign empty_mask[s] = (ranks[s*RANK_W +: RANK_W] == '0);
        assign slot_irq[s]   = !empty_mask[s];
    end

    assign free_mask = empty_mask & (ctrl_q[3] ? {NSLOT{1'b1}} : NSLOT'(1));

    rxfb_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start   (rx_start),
        .rx_valid   (rx_valid),
        .rx_end     (rx_end),
        .free_mask  (free_mask),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_idx     (wr_idx),
        .commit     (commit),
        .commit_len (commit_len),
        .ovf_set    (ovf_set)
    );

    rxfb_slot_store u_store (
        .clk   (clk),
        .we    (wr_en),
        .wslot (wr_slot),
        .widx  (wr_idx),
        .wdata (rx_data),
        .rslot (reg_addr[ADDR_W-1 -: SLOT_W]),
        .ridx  (reg_addr[IDX_W-1:0]),
        .rdata (store_rdata)
    );

    rxfb_age_tracker u_age (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .commit_slot  (wr_slot),
        .commit_len   (commit_len),
        .release_mask (release_mask),
        .clear_all    (clear_all),
        .ovf_set      (ovf_set),
        .ranks        (ranks),
        .lens         (lens),
        .overflow     (overflow)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[ADDR_W-1 -: SLOT_W] < SLOT_W'(NSLOT)) begin
            reg_rdata = store_rdata;
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (reg_addr == A_LEN_BASE + ADDR_W'(s))
                    reg_rdata = BYTE_W'(lens[s*LEN_W +: LEN_W]);
            end
            if (reg_addr == A_STATUS) reg_rdata = {overflow, 1'b0, ranks};
            if (reg_addr == A_CTRL)   reg_rdata = {4'b0, ctrl_q};
        end
    end
endmodule

// File: rtl/rx_frame_buffer_chk.sv
module rx_frame_buffer_chk
    import rxfb_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [BYTE_W-1:0]       reg_wdata,
    input logic                    rx_end,
    input logic [NSLOT-1:0]        slot_irq,
    input logic                    overflow,
    input logic [NSLOT*RANK_W-1:0] ranks,
    input logic [NSLOT*LEN_W-1:0]  lens,
    input logic [3:0]              ctrl_bits
);
    logic       wipe;
    logic [1:0] r0, r1, r2;
    logic [1:0] occ;

    assign wipe = reg_wr && reg_addr == A_CTRL && reg_wdata[3:0] == 4'hF;
    assign r0   = ranks[1:0];
    assign r1   = ranks[3:2];
    assign r2   = ranks[5:4];
    assign occ  = 2'((r0 != 0) + (r1 != 0) + (r2 != 0));

    // R2: occupied ranks are distinct
    a_r2_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
        (r0 == 0 || (r0 != r1 && r0 != r2)) && (r1 == 0 || r1 != r2));

    // R2: ranks never exceed the occupancy
    a_r2_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r0 <= occ && r1 <= occ && r2 <= occ);

    // R9: clear-all empties everything and drops the overflow flag
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (slot_irq == '0 && !overflow));

    // R8: overflow is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !wipe) |=> overflow);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // R5: length saturates at the frame limit
        a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
            lens[s*LEN_W +: LEN_W] <= LEN_W'(MAX_LEN));

        // R3: a slot becomes ready only after a frame end
        a_r3_irq_after_end: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slot_irq[s]) |-> $past(rx_end));

        // R6: a 1-then-0 clear write empties an occupied slot
        a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_CTRL && ctrl_bits[s] && !reg_wdata[s] && slot_irq[s])
            |=> !slot_irq[s]);
    end
endmodule

bind rx_frame_buffer rx_frame_buffer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_end    (rx_end),
    .slot_irq  (slot_irq),
    .overflow  (overflow),
    .ranks     (ranks),
    .lens      (lens),
    .ctrl_bits (ctrl_q)
);

// File: tb/rx_frame_buffer_tb.sv
module rx_frame_buffer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0] rx_data = '0;
    logic       reg_wr = 1'b0;
    logic [5:0] wr_addr = '0, mon_addr = '0, reg_addr;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [2:0] slot_irq;
    logic       overflow;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    typedef struct {
        bit         pins;
        logic [5:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;
    assign reg_addr = reg_wr ? wr_addr : mon_addr;

    rx_frame_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_irq(slot_irq),
        .overflow(overflow)
    );

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        item_t      it;
        logic [7:0] got;
        if (q.size() != 0) begin
            it = q.pop_front();
            if (!it.pins) mon_addr = it.addr;
            #2;
            got = it.pins ? {4'b0, overflow, slot_irq} : reg_rdata;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: addr %h got %h expected %h", it.tag, it.addr, got, it.exp);
            end
        end
    end

    task automatic exp_reg(input logic [5:0] a, input logic [7:0] v, input string tag);
        item_t it;
        it.pins = 1'b0; it.addr = a; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_pins(input logic [7:0] v, input string tag);
        item_t it;
        it.pins = 1'b1; it.addr = '0; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = base + 8'(i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    task automatic pulse_end();
        rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] base);
        pulse_start();
        push_bytes(n, base);
        pulse_end();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        exp_reg(6'h33, 8'h00, "R1 status");
        exp_reg(6'h34, 8'h00, "R1 ctrl");
        exp_reg(6'h30, 8'h00, "R1 len0");
        exp_pins(8'h00, "R1 pins");
        drain();

        // R7 single-slot mode: first frame to slot 0
        send_frame(3, 8'h10);
        exp_reg(6'h33, 8'h01, "R3 status single");
        exp_reg(6'h30, 8'h03, "R4 len0");
        exp_reg(6'h01, 8'h11, "R4 byte0.1");
        exp_pins(8'h01, "R3 irq0");
        drain();
        send_frame(2, 8'h55);
        exp_reg(6'h33, 8'h81, "R7 R8 single overflow");
        exp_pins(8'h09, "R8 pins");
        exp_reg(6'h01, 8'h11, "R8 slot0 untouched");
        drain();

        // R9 clear all
        reg_write(6'h34, 8'h0F);
        exp_reg(6'h33, 8'h00, "R9 status");
        exp_pins(8'h00, "R9 pins");
        exp_reg(6'h34, 8'h0F, "R9 ctrl");
        exp_reg(6'h30, 8'h00, "R9 len0");
        drain();
        reg_write(6'h34, 8'h08);

        // multi-slot fill
        send_frame(2, 8'h20);
        send_frame(20, 8'h40);
        exp_reg(6'h33, 8'h09, "R3 two frames");
        exp_reg(6'h31, 8'h10, "R5 len saturate");
        exp_reg(6'h10, 8'h40, "R4 slot1 header");
        exp_reg(6'h1F, 8'h4F, "R5 slot1 last");
        drain();
        send_frame(1, 8'h60);
        exp_reg(6'h33, 8'h39, "R2 three ranks");
        exp_reg(6'h32, 8'h01, "R4 len2");
        exp_reg(6'h20, 8'h60, "R4 slot2 byte");
        exp_pins(8'h07, "R3 all ready");
        drain();
        send_frame(4, 8'hA0);
        exp_reg(6'h33, 8'hB9, "R8 full overflow");
        exp_pins(8'h0F, "R8 pins full");
        exp_reg(6'h00, 8'h20, "R8 slot0 kept");
        drain();

        // R6 release oldest
        reg_write(6'h34, 8'h09);
        exp_reg(6'h33, 8'hB9, "R6 first write no effect");
        drain();
        reg_write(6'h34, 8'h08);
        exp_reg(6'h33, 8'hA4, "R6 ranks shift");
        exp_reg(6'h30, 8'h00, "R6 len cleared");
        exp_pins(8'h0E, "R6 pins");
        drain();

        // R10 empty frame
        pulse_start();
        pulse_end();
        exp_reg(6'h33, 8'hA4, "R10 unchanged");
        exp_pins(8'h0E, "R10 pins");
        drain();

        // R11 restart mid-frame
        pulse_start();
        push_bytes(3, 8'h70);
        pulse_start();
        push_bytes(2, 8'h80);
        pulse_end();
        exp_reg(6'h33, 8'hA7, "R11 status");
        exp_reg(6'h30, 8'h02, "R11 len");
        exp_reg(6'h00, 8'h80, "R11 byte0");
        exp_reg(6'h01, 8'h81, "R11 byte1");
        drain();

        // R6 release middle rank
        reg_write(6'h34, 8'h0C);
        reg_write(6'h34, 8'h08);
        exp_reg(6'h33, 8'h86, "R6 middle release");
        exp_pins(8'h0B, "R6 pins middle");
        drain();

        // R9 clear, then one fresh frame
        reg_write(6'h34, 8'h0F);
        exp_reg(6'h33, 8'h00, "R9 second clear");
        exp_pins(8'h00, "R9 pins second");
        drain();
        reg_write(6'h34, 8'h08);
        send_frame(1, 8'h99);
        exp_reg(6'h33, 8'h01, "R3 after clear");
        exp_reg(6'h00, 8'h99, "R4 after clear");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule